// File: doc/BRIEF.md
# AUX Request Byte Framer

This block turns a single auxiliary-channel transaction request into the ordered byte sequence that a downstream line encoder sends. A request is described by a native-or-I2C selector, a write flag, a middle-of-transaction (MOT) flag, a 20-bit target address and a payload length. For writes, the payload bytes come from a small internal buffer that the requester fills beforehand through a write port. The framer packs a 4-bit command and the address into a three-byte header. When the length is nonzero it adds a length-minus-one byte, then appends the payload on write commands. Bytes leave over a valid/ready stream.

A one-cycle `go` pulse starts a request. The framer first clears its sticky completion flag. It presents the first byte only after that flag reads low. Along with the stream, the framer holds the total transmit byte count and a start-delay value equal to ten times the caller's delay setting. Both stay valid until the next request. Line coding, preambles and reply parsing belong to other blocks.

Top module: `aux_req_framer`

## Requirements
- R1: The command nibble sent in bits 7:4 of the first byte is 4'b1000 for a native write, 4'b1001 for a native read, 4'b0000 for an I2C write, 4'b0100 for an I2C write with MOT, 4'b0001 for an I2C read and 4'b0101 for an I2C read with MOT. The MOT flag has no effect on native commands.
- R2: Bits 3:0 of the first byte carry address bits 19:16. The second byte is address bits 15:8 and the third byte is address bits 7:0.
- R3: A request with nonzero length sends a fourth byte equal to length minus one. A zero-length request sends only the three address bytes.
- R4: On write commands, payload buffer entries 0 through length-1 follow the header in ascending order. Read commands send no payload bytes.
- R5: `wr_count` equals the header size (3, or 4 when the length is nonzero), plus the length on write commands only. It also equals the number of bytes the stream delivers.
- R6: `start_dly` equals ten times `req_dly`, captured at `go`.
- R7: `go` clears `done` at the next clock edge, and `out_valid` stays low during that edge's cycle. `out_valid` never rises while `done` is high. `done` goes high once the last byte is accepted and stays high until the next accepted `go`.
- R8: A `go` pulse while `busy` is high is ignored. The frame in progress, `wr_count` and `start_dly` stay unchanged, and no new frame follows.
- R9: `busy` rises at the clock edge that samples `go` and falls at the edge where the last byte is accepted.
- R10: After reset `out_valid`, `busy` and `done` are low.
- R11: While `out_valid` is high and `out_ready` is low, `out_data` holds its value and `out_valid` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pb_we | input | 1 | Payload buffer write enable |
| pb_idx | input | IDX_W | Payload buffer write index |
| pb_data | input | 8 | Payload buffer write data |
| go | input | 1 | Start pulse for a request |
| req_i2c | input | 1 | 1 = I2C-over-AUX, 0 = native |
| req_wr | input | 1 | 1 = write command |
| req_mot | input | 1 | Middle-of-transaction flag (I2C only) |
| req_addr | input | 20 | Target address |
| req_len | input | LEN_W | Payload length, 0..MAX_LEN |
| req_dly | input | DLY_W | Caller start delay setting |
| start_dly | output | DLY_W+4 | Loaded start delay, ten times req_dly |
| wr_count | output | CNT_W | Total bytes of the frame |
| busy | output | 1 | Frame in progress |
| done | output | 1 | Sticky completion flag |
| out_valid | output | 1 | Stream byte valid |
| out_ready | input | 1 | Stream byte accepted |
| out_data | output | 8 | Stream byte |

## Verification
All six command variants are run. A native read with a nonzero length shows whether the payload is wrongly counted or sent on reads. Lengths of zero, one and the buffer maximum show whether the length byte appears only when it should and whether the last payload entry is reached. A stalled `out_ready` pattern shows whether bytes are held or skipped. A `go` pulse with different fields in the middle of a frame shows whether a busy framer re-latches or queues a second frame.

// File: rtl/aux_fr_pkg.sv
package aux_fr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACK  = 2'd1,
    ST_SEND = 2'd2
  } fr_state_t;

  localparam logic [3:0] CMD_NAT_WR = 4'b1000;
  localparam logic [3:0] CMD_NAT_RD = 4'b1001;
  localparam logic [3:0] CMD_I2C_WR = 4'b0000;
  localparam logic [3:0] CMD_I2C_RD = 4'b0001;
  localparam int         MOT_BIT    = 2;

endpackage

// File: rtl/aux_cmd_sel.sv
module aux_cmd_sel
  import aux_fr_pkg::*;
(
  input  logic       is_i2c,
  input  logic       is_wr,
  input  logic       mot,
  output logic [3:0] cmd
);

  always_comb begin
    if (!is_i2c) begin
      cmd = is_wr ? CMD_NAT_WR : CMD_NAT_RD;
    end else begin
      cmd = is_wr ? CMD_I2C_WR : CMD_I2C_RD;
      cmd[MOT_BIT] = mot;
    end
  end

endmodule

// File: rtl/aux_hdr_build.sv
module aux_hdr_build #(
  parameter int LEN_W = 5,
  parameter int CNT_W = 5
) (
  input  logic [3:0]       cmd,
  input  logic [19:0]      addr,
  input  logic [LEN_W-1:0] len,
  input  logic             is_wr,
  output logic [7:0]       hdr_b0,
  output logic [7:0]       hdr_b1,
  output logic [7:0]       hdr_b2,
  output logic [7:0]       hdr_len,
  output logic [2:0]       hdr_n,
  output logic [CNT_W-1:0] total
);

  logic has_len;

  assign has_len = (len != '0);
  assign hdr_b0  = {cmd, addr[19:16]};
  assign hdr_b1  = addr[15:8];
  assign hdr_b2  = addr[7:0];
  assign hdr_len = 8'(len) - 8'd1;
  assign hdr_n   = has_len ? 3'd4 : 3'd3;
  assign total   = CNT_W'(hdr_n) + (is_wr ? CNT_W'(len) : '0);

endmodule

// File: rtl/aux_pay_buf.sv
module aux_pay_buf #(
  parameter int DEPTH = 16,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  logic [7:0]       wdata,
  input  logic [IDX_W-1:0] ridx,
  output logic [7:0]       rdata
);

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[widx] <= wdata;
  end

  assign rdata = mem[ridx];

endmodule

// File: rtl/aux_req_framer.sv
module aux_req_framer
  import aux_fr_pkg::*;
#(
  parameter int MAX_LEN = 16,
  parameter int DLY_W   = 8,
  parameter int IDX_W   = $clog2(MAX_LEN),
  parameter int LEN_W   = $clog2(MAX_LEN + 1),
  parameter int CNT_W   = $clog2(MAX_LEN + 5)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pb_we,
  input  logic [IDX_W-1:0] pb_idx,
  input  logic [7:0]       pb_data,
  input  logic             go,
  input  logic             req_i2c,
  input  logic             req_wr,
  input  logic             req_mot,
  input  logic [19:0]      req_addr,
  input  logic [LEN_W-1:0] req_len,
  input  logic [DLY_W-1:0] req_dly,
  output logic [DLY_W+3:0] start_dly,
  output logic [CNT_W-1:0] wr_count,
  output logic             busy,
  output logic             done,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [7:0]       out_data
);

  localparam int SD_W = DLY_W + 4;

  fr_state_t        state;
  logic [3:0]       cmd_in, cmd_q;
  logic [19:0]      addr_q;
  logic [LEN_W-1:0] len_q;
  logic             wr_q;
  logic [CNT_W-1:0] idx;
  logic [7:0]       b0, b1, b2, blen, pay_rd;
  logic [2:0]       hdr_n;
  logic [CNT_W-1:0] total;
  logic [IDX_W-1:0] pay_idx;
  logic [7:0]       sel_byte;
  logic             accept_go;

  aux_cmd_sel u_cmd (
    .is_i2c (req_i2c),
    .is_wr  (req_wr),
    .mot    (req_mot),
    .cmd    (cmd_in)
  );

  aux_hdr_build #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_hdr (
    .cmd     (cmd_q),
    .addr    (addr_q),
    .len     (len_q),
    .is_wr   (wr_q),
    .hdr_b0  (b0),
    .hdr_b1  (b1),
    .hdr_b2  (b2),
    .hdr_len (blen),
    .hdr_n   (hdr_n),
    .total   (total)
  );

  aux_pay_buf #(.DEPTH(MAX_LEN), .IDX_W(IDX_W)) u_buf (
    .clk   (clk),
    .we    (pb_we),
    .widx  (pb_idx),
    .wdata (pb_data),
    .ridx  (pay_idx),
    .rdata (pay_rd)
  );

  assign pay_idx = IDX_W'(idx - CNT_W'(hdr_n));

  always_comb begin
    if (idx == CNT_W'(0))                         sel_byte = b0;
    else if (idx == CNT_W'(1))                    sel_byte = b1;
    else if (idx == CNT_W'(2))                    sel_byte = b2;
    else if (idx == CNT_W'(3) && hdr_n == 3'd4)   sel_byte = blen;
    else                                          sel_byte = pay_rd;
  end

  assign accept_go = (state == ST_IDLE) && go;
  assign busy      = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cmd_q     <= '0;
      addr_q    <= '0;
      len_q     <= '0;
      wr_q      <= 1'b0;
      idx       <= '0;
      wr_count  <= CNT_W'(3);
      start_dly <= '0;
      done      <= 1'b0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (accept_go) begin
            cmd_q     <= cmd_in;
            addr_q    <= req_addr;
            len_q     <= req_len;
            wr_q      <= req_wr;
            start_dly <= SD_W'(req_dly) * SD_W'(10);
            done      <= 1'b0;
            idx       <= '0;
            state     <= ST_ACK;
          end
        end
        ST_ACK: begin
          wr_count <= total;
          if (!done) begin
            out_data  <= sel_byte;
            out_valid <= 1'b1;
            idx       <= idx + CNT_W'(1);
            state     <= ST_SEND;
          end
        end
        ST_SEND: begin
          if (out_ready) begin
            if (idx == wr_count) begin
              out_valid <= 1'b0;
              done      <= 1'b1;
              state     <= ST_IDLE;
            end else begin
              out_data <= sel_byte;
              idx      <= idx + CNT_W'(1);
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_hold_on_stall_R11: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  assert_no_valid_while_done_R7: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !done);

  assert_valid_inside_busy_R9: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> busy);

  assert_go_ignored_busy_R8: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SEND && go) |=> $stable(start_dly));

  assert_count_range_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_count >= CNT_W'(3)) && (wr_count <= CNT_W'(MAX_LEN + 4)));

endmodule

// File: tb/aux_req_framer_tb.sv
`timescale 1ns/1ps
module aux_req_framer_tb_top;

  localparam int MAX_LEN = 16;
  localparam int DLY_W   = 8;
  localparam int IDX_W   = $clog2(MAX_LEN);
  localparam int LEN_W   = $clog2(MAX_LEN + 1);
  localparam int CNT_W   = $clog2(MAX_LEN + 5);

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             pb_we = 1'b0;
  logic [IDX_W-1:0] pb_idx = '0;
  logic [7:0]       pb_data = '0;
  logic             go = 1'b0;
  logic             req_i2c = 1'b0, req_wr = 1'b0, req_mot = 1'b0;
  logic [19:0]      req_addr = '0;
  logic [LEN_W-1:0] req_len = '0;
  logic [DLY_W-1:0] req_dly = '0;
  logic [DLY_W+3:0] start_dly;
  logic [CNT_W-1:0] wr_count;
  logic             busy, done, out_valid;
  logic             out_ready = 1'b0;
  logic [7:0]       out_data;

  int tests = 0;
  int fails = 0;
  logic [7:0] pay [MAX_LEN];

  always #2.5 clk = ~clk;

  aux_req_framer #(.MAX_LEN(MAX_LEN), .DLY_W(DLY_W)) dut_i (
    .clk(clk), .rst(rst), .pb_we(pb_we), .pb_idx(pb_idx), .pb_data(pb_data),
    .go(go), .req_i2c(req_i2c), .req_wr(req_wr), .req_mot(req_mot),
    .req_addr(req_addr), .req_len(req_len), .req_dly(req_dly),
    .start_dly(start_dly), .wr_count(wr_count), .busy(busy), .done(done),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_cmd(input bit i2c, input bit wr, input bit mot);
    case ({i2c, wr, mot})
      3'b010, 3'b011: return 4'b1000;
      3'b000, 3'b001: return 4'b1001;
      3'b110:         return 4'b0000;
      3'b111:         return 4'b0100;
      3'b100:         return 4'b0001;
      default:        return 4'b0101;
    endcase
  endfunction

  task automatic load_payload(input int seed);
    for (int i = 0; i < MAX_LEN; i++) begin
      pay[i] = 8'((seed + i * 37) & 8'hff);
      @(negedge clk);
      pb_we = 1'b1; pb_idx = IDX_W'(i); pb_data = pay[i];
    end
    @(negedge clk);
    pb_we = 1'b0;
  endtask

  task automatic run_case(input string name, input bit i2c, input bit wr,
                          input bit mot, input logic [19:0] a, input int len,
                          input int dly, input bit stall, input bit inject);
    logic [7:0] got [32];
    logic [7:0] exp [32];
    int n = 0, en = 0, cyc = 0, hdr;
    bit prev_hold = 0, hold_err = 0;
    logic [7:0] hold_d = '0;
    int bad0, bad12, badl, badp;

    hdr = (len != 0) ? 4 : 3;
    exp[0] = {exp_cmd(i2c, wr, mot), a[19:16]};
    exp[1] = a[15:8];
    exp[2] = a[7:0];
    if (len != 0) exp[3] = 8'(len - 1);
    en = hdr;
    if (wr) for (int i = 0; i < len; i++) begin exp[en] = pay[i]; en++; end

    @(negedge clk);
    req_i2c = i2c; req_wr = wr; req_mot = mot; req_addr = a;
    req_len = LEN_W'(len); req_dly = DLY_W'(dly); go = 1'b1;
    @(negedge clk);
    go = 1'b0;
    // R7 R9: done cleared, busy up, no byte yet in the cycle after go
    chk(!out_valid && !done && busy, "R7", {name, " ack cycle valid/done/busy"},
        {out_valid, done, busy}, 3'b001);

    while (busy && cyc < 2000) begin
      bit rdy;
      rdy = stall ? ((cyc % 3) != 2) : 1'b1;
      out_ready = rdy;
      if (prev_hold && (!out_valid || out_data != hold_d)) hold_err = 1;
      prev_hold = out_valid && !rdy;
      hold_d = out_data;
      if (out_valid && rdy && n < 32) begin got[n] = out_data; n++; end
      if (inject && cyc == 2) begin
        go = 1'b1; req_addr = ~a; req_len = LEN_W'(1); req_wr = ~wr;
        req_dly = DLY_W'(dly + 3);
      end else go = 1'b0;
      @(negedge clk);
      cyc++;
    end
    go = 1'b0;
    out_ready = 1'b0;

    bad0 = 0; bad12 = 0; badl = 0; badp = 0;
    if (n >= 1 && got[0] != exp[0]) bad0 = 1;
    for (int i = 1; i < 3; i++) if (n > i && got[i] != exp[i]) bad12 = 1;
    if (len != 0 && n > 3 && got[3] != exp[3]) badl = 1;
    for (int i = hdr; i < en; i++) if (n > i && got[i] != exp[i]) badp = 1;

    chk(bad0 == 0, "R1", {name, " command/addr byte 0"}, got[0], exp[0]);
    chk(bad12 == 0, "R2", {name, " address bytes 1-2"}, {got[1], got[2]}, {exp[1], exp[2]});
    chk(badl == 0, "R3", {name, " length byte"}, got[3], exp[3]);
    chk(n == en, "R4", {name, " bytes delivered"}, n, en);
    chk(badp == 0, "R4", {name, " payload order"}, badp, 0);
    chk(int'(wr_count) == en, "R5", {name, " wr_count"}, wr_count, en);
    chk(int'(start_dly) == dly * 10, "R6", {name, " start delay"}, start_dly, dly * 10);
    chk(done && !busy, "R7", {name, " done after last byte"}, {done, busy}, 2'b10);
    if (stall) chk(!hold_err, "R11", {name, " hold under stall"}, hold_err, 0);
    if (inject) begin
      bit extra = 0;
      for (int i = 0; i < 5; i++) begin
        if (busy || out_valid) extra = 1;
        @(negedge clk);
      end
      chk(!extra, "R8", {name, " no frame after ignored go"}, extra, 0);
    end
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(!out_valid && !busy && !done, "R10", "reset outputs",
        {out_valid, busy, done}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!out_valid && !busy && !done, "R10", "idle after reset",
        {out_valid, busy, done}, 0);
  endtask

  initial begin
    #(5ns * 150000);
    fails++;
    tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    t_reset();
    load_payload(11);
    run_case("native write len3",     0, 1, 0, 20'hA1234, 3,  5,   0, 0);
    run_case("native read len16",     0, 0, 1, 20'h00F0E, 16, 0,   0, 0);
    run_case("native read len0",      0, 0, 0, 20'hFFFFF, 0,  255, 0, 0);
    run_case("i2c write mot len1",    1, 1, 1, 20'h00050, 1,  1,   1, 0);
    run_case("i2c write len16",       1, 1, 0, 20'h5A5A5, 16, 12,  1, 0);
    load_payload(200);
    run_case("i2c read len0",         1, 0, 0, 20'h00037, 0,  7,   0, 0);
    run_case("i2c read mot len5",     1, 0, 1, 20'h3C3C3, 5,  9,   1, 0);
    run_case("native write go-busy",  0, 1, 0, 20'h12345, 6,  20,  0, 1);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule